// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt sources of a 16550-style serial controller into one level-sensitive request line and an 8-bit identification value. It receives the status of the line, receive, transmit and modem paths and holds two pieces of state of its own: the 4-bit interrupt enable register and a hidden "transmit holding empty" pending flag. From these it picks the single highest-priority enabled source. The choice is combinational, so the request follows its sources in the same cycle.

A host read of the identification value is signalled with a strobe. If that read returns the transmit-empty code, the pending flag clears and the next lower source takes its place. Writing the enable register re-arms the transmit-empty flag whenever the holding register is empty. The FIFOs, the data path and the serial shifting live outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the transmit-empty pending flag is clear, `irq` is 0 and `iir` reads 0x01 while `fifo_en` is 0.
- R2: When enable bit 2 is set and any bit of `lsr_err` is set (bit 0 overrun, 1 parity, 2 framing, 3 break), `iir[3:0]` is 0x6. This outranks every other source.
- R3: When enable bit 0 is set and `rx_timeout` is 1, with no line-status interrupt, `iir[3:0]` is 0xC. No other enable bit can raise this code, and with enable bit 0 clear the timeout never shows.
- R4: Receive-data-available shows as `iir[3:0]` = 0x4. It needs enable bit 0, `data_ready`, and no higher source. With `fifo_en` = 1 it also needs `rx_count` >= `rx_trigger`; with `fifo_en` = 0 `data_ready` alone is enough.
- R5: When enable bit 1 is set and the transmit-empty pending flag is set, with no higher source, `iir[3:0]` is 0x2.
- R6: When enable bit 3 is set and any bit of `msr_delta` is set, with no higher source, `iir[3:0]` is 0x0.
- R7: When no enabled source is active, `iir[3:0]` is 0x1 and `irq` is 0. Otherwise `irq` is 1. `iir[5:4]` always reads 0.
- R8: `iir[7:6]` reads 11 when `fifo_en` is 1 and 00 when it is 0.
- R9: An `iir_rd` pulse taken while `iir[3:0]` is 0x2 clears the pending flag from the next cycle. A read that shows any other code leaves the flag unchanged.
- R10: An `ier_wr` pulse stores only `ier_wdata[3:0]`, which then reads on `ier`. If `thr_empty` is 1 during that write, the pending flag is set from the next cycle.
- R11: A `tx_done` pulse sets the pending flag and a `thr_wr` pulse clears it. A set takes effect over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | 8 | Write data for the enable register |
| iir_rd | input | 1 | Host read strobe of the identification value |
| thr_wr | input | 1 | Host wrote the transmit holding register |
| thr_empty | input | 1 | Transmit holding register is empty |
| tx_done | input | 1 | Holding register just became empty |
| lsr_err | input | 4 | Line error flags: overrun, parity, framing, break |
| data_ready | input | 1 | Receive data present |
| fifo_en | input | 1 | FIFO mode active |
| rx_count | input | CNT_W | Receive FIFO fill level |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| rx_timeout | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change flags |
| ier | output | 4 | Stored enable register |
| irq | output | 1 | Level interrupt request |
| iir | output | 8 | Identification value |

## Verification
The assertions assume that every status input is a clean level held for whole cycles and that `rx_count` and `rx_trigger` stay within 0 to FIFO_DEPTH. They also assume that strobes are single-cycle and are driven only from reset release onward. The bench changes inputs only at falling edges and holds every strobe for exactly one cycle. It keeps counts and trigger levels within the range of a 16-entry FIFO and keeps `thr_empty` low except where the re-arm on an enable write is being tested. Status levels are applied only after the enable register and the pending flag have settled, so each check sees a stable combination.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   typedef enum logic [3:0] {
      ID_MODEM = 4'h0,
      ID_NONE  = 4'h1,
      ID_THRE  = 4'h2,
      ID_RXD   = 4'h4,
      ID_LINE  = 4'h6,
      ID_TMO   = 4'hC
   } irq_id_e;

   localparam int unsigned IER_BITS = 4;
   localparam int unsigned ERR_BITS = 4;
   localparam int unsigned DLT_BITS = 4;
endpackage

// File: rtl/irqid_enable_reg.sv
module irqid_enable_reg
   import uart_irq_pkg::*;
#(
   parameter int unsigned WDATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [WDATA_W-1:0]  wdata,
   output logic [IER_BITS-1:0] ier_q
);
   if (WDATA_W < IER_BITS) begin : g_bad_width
      $error("WDATA_W must cover the enable bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  ier_q <= '0;
      else if (wr) ier_q <= wdata[IER_BITS-1:0];
   end

   assert_ier_keep_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ier_q == $past(wdata[IER_BITS-1:0]));
endmodule

// File: rtl/irqid_thre_flag.sv
module irqid_thre_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic ier_wr,
   input  logic thr_empty,
   input  logic tx_done,
   input  logic thr_wr,
   input  logic id_rd,
   input  logic id_is_thre,
   output logic pend_q
);
   logic arm, disarm;

   assign arm    = tx_done || (ier_wr && thr_empty);
   assign disarm = thr_wr || (id_rd && id_is_thre);

   always_ff @(posedge clk) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (arm)    pend_q <= 1'b1;
      else if (disarm) pend_q <= 1'b0;
   end

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && id_is_thre && !tx_done && !(ier_wr && thr_empty)) |=> !pend_q);
   assert_other_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && !id_is_thre && !thr_wr && !tx_done && !ier_wr) |=> pend_q == $past(pend_q));
   assert_ier_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_wr && thr_empty) |=> pend_q);
   assert_tx_done_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> pend_q);
endmodule

// File: rtl/irqid_prio.sv
module irqid_prio
   import uart_irq_pkg::*;
#(
   parameter int unsigned CNT_W        = 5,
   parameter bit          FIFO_CAPABLE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IER_BITS-1:0] ier,
   input  logic [ERR_BITS-1:0] lsr_err,
   input  logic                data_ready,
   input  logic                fifo_en,
   input  logic [CNT_W-1:0]    rx_count,
   input  logic [CNT_W-1:0]    rx_trigger,
   input  logic                rx_timeout,
   input  logic                thre_pend,
   input  logic [DLT_BITS-1:0] msr_delta,
   output irq_id_e             id,
   output logic                req
);
   logic src_line, src_tmo, src_rxd, src_thre, src_modem, rx_level_ok;

   if (FIFO_CAPABLE) begin : g_fifo_gate
      assign rx_level_ok = !fifo_en || (rx_count >= rx_trigger);
   end else begin : g_plain_gate
      assign rx_level_ok = 1'b1;
   end

   assign src_line  = ier[2] && (|lsr_err);
   assign src_tmo   = ier[0] && rx_timeout;
   assign src_rxd   = ier[0] && data_ready && rx_level_ok;
   assign src_thre  = ier[1] && thre_pend;
   assign src_modem = ier[3] && (|msr_delta);

   always_comb begin
      if (src_line)       id = ID_LINE;
      else if (src_tmo)   id = ID_TMO;
      else if (src_rxd)   id = ID_RXD;
      else if (src_thre)  id = ID_THRE;
      else if (src_modem) id = ID_MODEM;
      else                id = ID_NONE;
   end

   assign req = (id != ID_NONE);

   assert_line_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ier[2] && lsr_err != '0) |-> id == ID_LINE);
   assert_tmo_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ier[0] |-> (id != ID_TMO && id != ID_RXD));
   assert_modem_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (id == ID_MODEM) |-> (ier[3] && msr_delta != '0));
   assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == '0) |-> !req);

   if (FIFO_CAPABLE) begin : g_fifo_chk
      assert_below_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (fifo_en && rx_count < rx_trigger) |-> id != ID_RXD);
   end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH   = 16,
   parameter bit          FIFO_CAPABLE = 1'b1,
   localparam int unsigned CNT_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ier_wr,
   input  logic [7:0]       ier_wdata,
   input  logic             iir_rd,
   input  logic             thr_wr,
   input  logic             thr_empty,
   input  logic             tx_done,
   input  logic [3:0]       lsr_err,
   input  logic             data_ready,
   input  logic             fifo_en,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_trigger,
   input  logic             rx_timeout,
   input  logic [3:0]       msr_delta,
   output logic [3:0]       ier,
   output logic             irq,
   output logic [7:0]       iir
);
   if (FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be at least 2");
   end

   irq_id_e    cur_id;
   logic       thre_pend;
   logic [1:0] mode_bits;

   irqid_enable_reg #(.WDATA_W(8)) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ier_wr),
      .wdata (ier_wdata),
      .ier_q (ier)
   );

   irqid_thre_flag u_thre (
      .clk        (clk),
      .rst_n      (rst_n),
      .ier_wr     (ier_wr),
      .thr_empty  (thr_empty),
      .tx_done    (tx_done),
      .thr_wr     (thr_wr),
      .id_rd      (iir_rd),
      .id_is_thre (iir[3:0] == ID_THRE),
      .pend_q     (thre_pend)
   );

   irqid_prio #(.CNT_W(CNT_W), .FIFO_CAPABLE(FIFO_CAPABLE)) u_prio (
      .clk        (clk),
      .rst_n      (rst_n),
      .ier        (ier),
      .lsr_err    (lsr_err),
      .data_ready (data_ready),
      .fifo_en    (fifo_en),
      .rx_count   (rx_count),
      .rx_trigger (rx_trigger),
      .rx_timeout (rx_timeout),
      .thre_pend  (thre_pend),
      .msr_delta  (msr_delta),
      .id         (cur_id),
      .req        (irq)
   );

   if (FIFO_CAPABLE) begin : g_mode_fifo
      assign mode_bits = {2{fifo_en}};
   end else begin : g_mode_plain
      assign mode_bits = 2'b00;
   end

   assign iir = {mode_bits, 2'b00, cur_id};

   assert_irq_matches_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iir[0]);
   if (FIFO_CAPABLE) begin : g_mode_chk
      assert_fifo_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
         iir[7:6] == (fifo_en ? 2'b11 : 2'b00));
   end
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
   localparam int PERIOD = 10;
   localparam int NV = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ier_wr = 0, iir_rd = 0, thr_wr = 0, thr_empty = 0, tx_done = 0;
   logic [7:0] ier_wdata = 0;
   logic [3:0] lsr_err = 0, msr_delta = 0;
   logic data_ready = 0, fifo_en = 0, rx_timeout = 0;
   logic [4:0] rx_count = 0, rx_trigger = 0;
   logic [3:0] ier;
   logic irq;
   logic [7:0] iir;
   int n_vec = 0, n_bad = 0;
   bit finished = 0;

   always #(PERIOD/2) clk = ~clk;

   uart_irq_ident u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .iir_rd(iir_rd), .thr_wr(thr_wr), .thr_empty(thr_empty), .tx_done(tx_done),
      .lsr_err(lsr_err), .data_ready(data_ready), .fifo_en(fifo_en),
      .rx_count(rx_count), .rx_trigger(rx_trigger), .rx_timeout(rx_timeout),
      .msr_delta(msr_delta), .ier(ier), .irq(irq), .iir(iir)
   );

   // {ier, lsr_err, data_ready, fifo_en, rx_count, rx_trigger, rx_timeout, msr_delta, pend, expected iir}
   localparam logic [33:0] VEC [NV] = '{
      {4'hF, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 1'b0, 8'h01},
      {4'hF, 4'h1, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'hF, 1'b1, 8'h06},
      {4'hF, 4'h8, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'hF, 1'b1, 8'h06},
      {4'hB, 4'h1, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'hF, 1'b1, 8'h0C},
      {4'hE, 4'h0, 1'b1, 1'b0, 5'd0,  5'd1,  1'b1, 4'hF, 1'b1, 8'h02},
      {4'hF, 4'h0, 1'b1, 1'b0, 5'd0,  5'd1,  1'b0, 4'hF, 1'b1, 8'h04},
      {4'hF, 4'h0, 1'b1, 1'b1, 5'd3,  5'd4,  1'b0, 4'hF, 1'b1, 8'hC2},
      {4'hF, 4'h0, 1'b1, 1'b1, 5'd4,  5'd4,  1'b0, 4'hF, 1'b1, 8'hC4},
      {4'hF, 4'h0, 1'b1, 1'b1, 5'd14, 5'd14, 1'b0, 4'hF, 1'b1, 8'hC4},
      {4'hF, 4'h0, 1'b0, 1'b1, 5'd8,  5'd4,  1'b0, 4'hF, 1'b0, 8'hC0},
      {4'h7, 4'h0, 1'b0, 1'b1, 5'd0,  5'd1,  1'b0, 4'hF, 1'b0, 8'hC1},
      {4'h8, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h1, 1'b0, 8'h00},
      {4'h2, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 1'b1, 8'h02},
      {4'hD, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 1'b1, 8'h01},
      {4'h0, 4'hF, 1'b1, 1'b1, 5'd10, 5'd1,  1'b1, 4'hF, 1'b1, 8'hC1},
      {4'h4, 4'h4, 1'b0, 1'b0, 5'd0,  5'd1,  1'b0, 4'h0, 1'b0, 8'h06},
      {4'h1, 4'h0, 1'b0, 1'b0, 5'd0,  5'd1,  1'b1, 4'h0, 1'b0, 8'h0C}
   };

   function automatic string tag_of(input logic [3:0] code);
      case (code)
         4'h6: return "R2";
         4'hC: return "R3";
         4'h4: return "R4";
         4'h2: return "R5";
         4'h0: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse_ier(input logic [7:0] d);
      @(negedge clk); ier_wr = 1'b1; ier_wdata = d;
      @(negedge clk); ier_wr = 1'b0;
   endtask

   task automatic pulse_tx_done();
      @(negedge clk); tx_done = 1'b1;
      @(negedge clk); tx_done = 1'b0;
   endtask

   task automatic pulse_thr_wr();
      @(negedge clk); thr_wr = 1'b1;
      @(negedge clk); thr_wr = 1'b0;
   endtask

   task automatic pulse_iir_rd();
      @(negedge clk); iir_rd = 1'b1;
      @(negedge clk); iir_rd = 1'b0;
   endtask

   task automatic quiet_inputs();
      lsr_err = 0; data_ready = 0; fifo_en = 0; rx_count = 0;
      rx_trigger = 5'd1; rx_timeout = 0; msr_delta = 0;
   endtask

   task automatic settle();
      #(PERIOD/4);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual=hung expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      quiet_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1: reset state
      check("R1", iir, 8'h01);
      check("R1", {7'd0, irq}, 8'h00);
      check("R1", {4'd0, ier}, 8'h00);
      // R1: pending flag clear after reset (shows only once enabled)
      pulse_ier(8'h02); settle();
      check("R1", iir, 8'h01);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [33:0] v;
         v = VEC[i];
         @(negedge clk); quiet_inputs();
         pulse_ier({4'h5, v[33:30]});
         if (v[8]) pulse_tx_done(); else pulse_thr_wr();
         lsr_err = v[29:26]; data_ready = v[25]; fifo_en = v[24];
         rx_count = v[23:19]; rx_trigger = v[18:14]; rx_timeout = v[13];
         msr_delta = v[12:9];
         settle();
         check(tag_of(v[3:0]), iir, v[7:0]);
         check("R7", {7'd0, irq}, {7'd0, ~v[0]});
         check("R8", {6'd0, iir[7:6]}, {6'd0, {2{v[24]}}});
      end

      // R10: only low four bits stored
      @(negedge clk); quiet_inputs();
      pulse_ier(8'hFF); settle();
      check("R10", {4'd0, ier}, 8'h0F);
      pulse_ier(8'hA6); settle();
      check("R10", {4'd0, ier}, 8'h06);

      // R11: thr_wr clears pending
      pulse_ier(8'h02);
      pulse_tx_done(); settle();
      check("R11", iir, 8'h02);
      pulse_thr_wr(); settle();
      check("R11", iir, 8'h01);

      // R10: enable write with holding register empty re-arms
      @(negedge clk); thr_empty = 1'b1;
      pulse_ier(8'h02);
      @(negedge clk); thr_empty = 1'b0;
      settle();
      check("R10", iir, 8'h02);

      // R9: reading the transmit-empty code clears it
      pulse_iir_rd(); settle();
      check("R9", iir, 8'h01);
      check("R9", {7'd0, irq}, 8'h00);

      // R9: a read showing another code keeps the flag
      pulse_ier(8'h06);
      pulse_tx_done();
      @(negedge clk); lsr_err = 4'h2;
      settle();
      check("R2", iir, 8'h06);
      pulse_iir_rd();
      @(negedge clk); lsr_err = 4'h0;
      settle();
      check("R9", iir, 8'h02);

      // R11: set wins over clear in the same cycle
      pulse_thr_wr(); settle();
      check("R11", iir, 8'h01);
      @(negedge clk); tx_done = 1'b1; thr_wr = 1'b1;
      @(negedge clk); tx_done = 1'b0; thr_wr = 1'b0;
      settle();
      check("R11", iir, 8'h02);

      // R4: non-FIFO mode ignores count below trigger
      @(negedge clk); data_ready = 1'b1; rx_count = 5'd0; rx_trigger = 5'd8;
      pulse_ier(8'h01); settle();
      check("R4", iir, 8'h04);
      @(negedge clk); fifo_en = 1'b1; settle();
      check("R4", iir, 8'hC1);

      finished = 1;
      summary();
      $finish;
   end
endmodule